// File: doc/BRIEF.md
# Integer Vector Execution Slice

This block is the integer datapath of one lane in a shader-style vector processor. Each issued operation supplies an 8-bit opcode, two operands, a 2-bit conditioning code for each operand and a 2-bit code that selects how the result is finished. The slice covers these families:

- plain, shifted and saturating add and subtract;
- signed and unsigned minimum and maximum;
- truncating and rounding halving adds;
- the three shifts;
- the eight two-input logic functions;
- leading-zero count, per-byte population count and move;
- signed and unsigned absolute difference.

Arithmetic is carried out on a double-width intermediate, so the finishing stage can do one of four things: clamp the value to the signed range, clamp it to the unsigned range, keep its low half, or return the bits that overflowed into its upper half. The result is registered one clock after an issue. An opcode outside the supported set returns zero and raises a flag.

Operand conditioning happens before any arithmetic. An operand can be sign-extended or zero-extended into the wide intermediate. It can instead take the extension the opcode implies. It can also be moved up by half a word and then take that implied extension. This makes it possible to add a half-word quantity into the upper half of a word, or to reinterpret an operand's signedness, without spending a separate instruction.

Top module: `ivec_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `o_valid`, `o_result` and `o_illegal` become 0.
- R2: When `i_valid` is high at an edge, the result and illegal flag appear on the outputs after that edge, and `o_valid` is 1. When `i_valid` is low at an edge, `o_result` and `o_illegal` hold their values and `o_valid` is 0.
- R3: Opcode 0x40 adds, 0x46 subtracts (a - b) and 0x41 computes a + (b << 1). All three work on the double-width intermediate.
- R4: Opcodes 0x48 and 0x49 add with saturation, signed and unsigned. Opcodes 0x4E and 0x4F subtract with saturation, signed and unsigned. Each clamps the exact sum or difference to the word range of its signedness.
- R5: Opcodes 0x60, 0x61, 0x62 and 0x63 give the signed minimum, unsigned minimum, signed maximum and unsigned maximum of the two conditioned operands.
- R6: Opcodes 0x64 and 0x65 give (a + b) >> 1, signed and unsigned. Opcodes 0x66 and 0x67 give (a + b + 1) >> 1, signed and unsigned. No carry is lost, so the unsigned rounding average of 0xFFFFFFFF and 0xFFFFFFFE is 0xFFFFFFFF.
- R7: Opcode 0x68 shifts right arithmetically, 0x69 shifts right logically and 0x6E shifts left. The shift amount is the low 5 bits of b. For a left shift, the bits shifted out form the upper half of the intermediate.
- R8: Opcodes 0x70 to 0x77 give the following functions, in opcode order:
  - a AND b
  - a OR b
  - NOT (a AND b)
  - NOT (a OR b)
  - a AND NOT b
  - a OR NOT b
  - a XOR b
  - NOT (a XOR b)
- R9: Opcode 0x78 counts leading zeros, and a zero operand gives the word width. Opcode 0x7A places the count of set bits of byte k of a in result bits [8k+7:8k]. Opcode 0x7B moves a.
- R10: Opcodes 0x7C and 0x7D give |a - b| of the conditioned operands, signed and unsigned.
- R11: The operand code works as follows:
  - 0: sign-extend into the intermediate.
  - 1: zero-extend into the intermediate.
  - 2: extend as the opcode implies. Opcodes 0x49, 0x4F, 0x61, 0x63, 0x65, 0x67 and 0x7D imply zero extension; the others imply sign extension.
  - 3: shift the operand left by 16 bits inside the word, then extend as with code 2.
- R12: The finishing code works as follows:
  - 0: clamp the intermediate to the signed word range.
  - 1: clamp it to the unsigned word range, with negative values going to 0.
  - 2: keep its low word.
  - 3: return its upper word.
  Results of opcodes 0x70 to 0x7A ignore codes 0 to 2, and code 3 gives 0 for them.
- R13: An unsupported opcode gives `o_result` = 0 and `o_illegal` = 1 whatever the finishing code. A supported opcode gives `o_illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | Issue strobe; the inputs are captured when it is high |
| i_op | input | 8 | Operation code |
| i_a | input | 32 | First operand |
| i_b | input | 32 | Second operand |
| i_amod | input | 2 | Conditioning code for the first operand |
| i_bmod | input | 2 | Conditioning code for the second operand |
| i_omod | input | 2 | Finishing code for the result |
| o_valid | output | 1 | High the cycle after an issue |
| o_result | output | 32 | Registered result |
| o_illegal | output | 1 | Registered unsupported-opcode flag |

## Verification
Operand conditioning and result finishing both act on the same operation, and they interact most sharply when the half-word shift moves a value into the sign bit just before a clamp. The bench issues an add whose first operand 0x00008000 uses the shift code and whose second operand is -1. It repeats that add under every finishing code and compares the results with hand-derived values: 0x80000000 when clamped signed, 0 when clamped unsigned, 0x7FFFFFFF when wrapped, and 0xFFFFFFFF as the upper word. A second overlap is between an unsupported opcode and the high-word finish. The bench checks that the zero result and the flag win over the finish.

// File: rtl/ivec_alu_pkg.sv
package ivec_alu_pkg;

   localparam logic [7:0] OP_ADD      = 8'h40;
   localparam logic [7:0] OP_ADD_SHB  = 8'h41;
   localparam logic [7:0] OP_SUB      = 8'h46;
   localparam logic [7:0] OP_QADD_S   = 8'h48;
   localparam logic [7:0] OP_QADD_U   = 8'h49;
   localparam logic [7:0] OP_QSUB_S   = 8'h4E;
   localparam logic [7:0] OP_QSUB_U   = 8'h4F;
   localparam logic [7:0] OP_MIN_S    = 8'h60;
   localparam logic [7:0] OP_MIN_U    = 8'h61;
   localparam logic [7:0] OP_MAX_S    = 8'h62;
   localparam logic [7:0] OP_MAX_U    = 8'h63;
   localparam logic [7:0] OP_AVG_S    = 8'h64;
   localparam logic [7:0] OP_AVG_U    = 8'h65;
   localparam logic [7:0] OP_RAVG_S   = 8'h66;
   localparam logic [7:0] OP_RAVG_U   = 8'h67;
   localparam logic [7:0] OP_SRA      = 8'h68;
   localparam logic [7:0] OP_SRL      = 8'h69;
   localparam logic [7:0] OP_SLL      = 8'h6E;
   localparam logic [7:0] OP_AND      = 8'h70;
   localparam logic [7:0] OP_OR       = 8'h71;
   localparam logic [7:0] OP_NAND     = 8'h72;
   localparam logic [7:0] OP_NOR      = 8'h73;
   localparam logic [7:0] OP_ANDN     = 8'h74;
   localparam logic [7:0] OP_ORN      = 8'h75;
   localparam logic [7:0] OP_XOR      = 8'h76;
   localparam logic [7:0] OP_XNOR     = 8'h77;
   localparam logic [7:0] OP_LZC      = 8'h78;
   localparam logic [7:0] OP_BYTEPOP  = 8'h7A;
   localparam logic [7:0] OP_MOV      = 8'h7B;
   localparam logic [7:0] OP_ADIFF_S  = 8'h7C;
   localparam logic [7:0] OP_ADIFF_U  = 8'h7D;

   typedef enum logic [1:0] {
      SRC_SEXT   = 2'd0,
      SRC_ZEXT   = 2'd1,
      SRC_NATIVE = 2'd2,
      SRC_UPHALF = 2'd3
   } src_mode_e;

   typedef enum logic [1:0] {
      FIN_CLAMP_S = 2'd0,
      FIN_CLAMP_U = 2'd1,
      FIN_WRAP    = 2'd2,
      FIN_UPPER   = 2'd3
   } fin_mode_e;

   function automatic logic op_native_unsigned(input logic [7:0] op);
      return op inside {OP_QADD_U, OP_QSUB_U, OP_MIN_U, OP_MAX_U,
                        OP_AVG_U, OP_RAVG_U, OP_ADIFF_U};
   endfunction

endpackage

// File: rtl/ivec_src_mod.sv
module ivec_src_mod
   import ivec_alu_pkg::*;
#(
   parameter int W  = 32,
   parameter int HS = W / 2
) (
   input  logic [1:0]     mode,
   input  logic           native_unsigned,
   input  logic [W-1:0]   x,
   output logic [W-1:0]   raw,
   output logic [2*W-1:0] wide
);
   logic fill_sign;

   always_comb begin
      raw = (mode == SRC_UPHALF) ? (x << HS) : x;
      unique case (mode)
         SRC_SEXT: fill_sign = 1'b1;
         SRC_ZEXT: fill_sign = 1'b0;
         default:  fill_sign = !native_unsigned;
      endcase
      wide = {{W{fill_sign & raw[W-1]}}, raw};
   end
endmodule

// File: rtl/ivec_exec.sv
module ivec_exec
   import ivec_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [7:0]     op,
   input  logic [W-1:0]   a_raw,
   input  logic [W-1:0]   b_raw,
   input  logic [2*W-1:0] a_wide,
   input  logic [2*W-1:0] b_wide,
   output logic [2*W-1:0] full,
   output logic           bitwise,
   output logic           illegal
);
   localparam int WW    = 2 * W;
   localparam int SH_W  = $clog2(W);
   localparam int NBYTE = W / 8;

   logic [WW-1:0] sum, dif, sum_rnd, sum_shb, mag, shl_w, shr_w, sra_w;
   logic [WW-1:0] min_v, max_v;
   logic [SH_W-1:0] shamt;
   logic [W-1:0]  bytepop;
   logic [SH_W:0] lzc;
   logic          a_lt_b;

   function automatic logic [WW-1:0] clamp_signed(input logic [WW-1:0] v);
      if ((&v[WW-1:W-1]) || !(|v[WW-1:W-1])) return v;
      else if (v[WW-1]) return {{(W+1){1'b1}}, {(W-1){1'b0}}};
      else return {{(W+1){1'b0}}, {(W-1){1'b1}}};
   endfunction

   function automatic logic [WW-1:0] clamp_unsigned(input logic [WW-1:0] v);
      if (v[WW-1]) return '0;
      else if (|v[WW-1:W]) return {{W{1'b0}}, {W{1'b1}}};
      else return v;
   endfunction

   function automatic logic [SH_W:0] lead_zeros(input logic [W-1:0] v);
      logic [SH_W:0] n;
      logic hit;
      n = '0;
      hit = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (v[i]) hit = 1'b1;
         else if (!hit) n = n + 1'b1;
      end
      return n;
   endfunction

   for (genvar k = 0; k < NBYTE; k++) begin : g_bytepop
      assign bytepop[8*k +: 8] = 8'($countones(a_raw[8*k +: 8]));
   end

   always_comb begin
      shamt   = b_raw[SH_W-1:0];
      sum     = a_wide + b_wide;
      dif     = a_wide - b_wide;
      sum_rnd = sum + WW'(1);
      sum_shb = a_wide + (b_wide << 1);
      mag     = dif[WW-1] ? (~dif + WW'(1)) : dif;
      a_lt_b  = $signed(a_wide) < $signed(b_wide);
      min_v   = a_lt_b ? a_wide : b_wide;
      max_v   = a_lt_b ? b_wide : a_wide;
      shl_w   = {{W{1'b0}}, a_raw} << shamt;
      shr_w   = {{W{1'b0}}, a_raw} >> shamt;
      sra_w   = WW'($signed({{W{a_raw[W-1]}}, a_raw}) >>> shamt);
      lzc     = lead_zeros(a_raw);
   end

   always_comb begin
      full    = '0;
      bitwise = 1'b0;
      illegal = 1'b0;
      unique case (op)
         OP_ADD:     full = sum;
         OP_SUB:     full = dif;
         OP_ADD_SHB: full = sum_shb;
         OP_QADD_S:  full = clamp_signed(sum);
         OP_QADD_U:  full = clamp_unsigned(sum);
         OP_QSUB_S:  full = clamp_signed(dif);
         OP_QSUB_U:  full = clamp_unsigned(dif);
         OP_MIN_S, OP_MIN_U: full = min_v;
         OP_MAX_S, OP_MAX_U: full = max_v;
         OP_AVG_S, OP_AVG_U:   full = WW'($signed(sum) >>> 1);
         OP_RAVG_S, OP_RAVG_U: full = WW'($signed(sum_rnd) >>> 1);
         OP_SRA:     full = sra_w;
         OP_SRL:     full = shr_w;
         OP_SLL:     full = shl_w;
         OP_MOV:     full = a_wide;
         OP_ADIFF_S, OP_ADIFF_U: full = mag;
         OP_AND:  begin bitwise = 1'b1; full[W-1:0] = a_raw & b_raw;    end
         OP_OR:   begin bitwise = 1'b1; full[W-1:0] = a_raw | b_raw;    end
         OP_NAND: begin bitwise = 1'b1; full[W-1:0] = ~(a_raw & b_raw); end
         OP_NOR:  begin bitwise = 1'b1; full[W-1:0] = ~(a_raw | b_raw); end
         OP_ANDN: begin bitwise = 1'b1; full[W-1:0] = a_raw & ~b_raw;   end
         OP_ORN:  begin bitwise = 1'b1; full[W-1:0] = a_raw | ~b_raw;   end
         OP_XOR:  begin bitwise = 1'b1; full[W-1:0] = a_raw ^ b_raw;    end
         OP_XNOR: begin bitwise = 1'b1; full[W-1:0] = ~(a_raw ^ b_raw); end
         OP_LZC:  begin bitwise = 1'b1; full[W-1:0] = W'(lzc);          end
         OP_BYTEPOP: begin bitwise = 1'b1; full[W-1:0] = bytepop;       end
         default: illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/ivec_finish.sv
module ivec_finish
   import ivec_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [2*W-1:0] full,
   input  logic           bitwise,
   input  logic           illegal,
   input  logic [1:0]     fin,
   output logic [W-1:0]   res
);
   localparam int WW = 2 * W;

   logic fits_s, fits_u;

   always_comb begin
      fits_s = (&full[WW-1:W-1]) || !(|full[WW-1:W-1]);
      fits_u = !(|full[WW-1:W]);
      if (illegal) begin
         res = '0;
      end else if (bitwise) begin
         res = (fin == FIN_UPPER) ? '0 : full[W-1:0];
      end else begin
         unique case (fin_mode_e'(fin))
            FIN_CLAMP_S: res = fits_s ? full[W-1:0]
                             : (full[WW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}});
            FIN_CLAMP_U: res = full[WW-1] ? '0 : (fits_u ? full[W-1:0] : '1);
            FIN_WRAP:    res = full[W-1:0];
            default:     res = full[WW-1:W];
         endcase
      end
   end
endmodule

// File: rtl/ivec_alu.sv
module ivec_alu
   import ivec_alu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int HALF_SHIFT = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              i_valid,
   input  logic [7:0]        i_op,
   input  logic [DATA_W-1:0] i_a,
   input  logic [DATA_W-1:0] i_b,
   input  logic [1:0]        i_amod,
   input  logic [1:0]        i_bmod,
   input  logic [1:0]        i_omod,
   output logic              o_valid,
   output logic [DATA_W-1:0] o_result,
   output logic              o_illegal
);
   localparam int WIDE_W = 2 * DATA_W;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("ivec_alu: DATA_W must be a multiple of 8 and at least 16");
   end
   if (HALF_SHIFT <= 0 || HALF_SHIFT >= DATA_W) begin : g_bad_shift
      $error("ivec_alu: HALF_SHIFT must lie inside the word");
   end

   logic [DATA_W-1:0] src_in   [2];
   logic [1:0]        src_mode [2];
   logic [DATA_W-1:0] src_raw  [2];
   logic [WIDE_W-1:0] src_wide [2];
   logic              native_uns;
   logic [WIDE_W-1:0] exec_full;
   logic              exec_bw, exec_ill;
   logic [DATA_W-1:0] fin_res;

   assign src_in[0]   = i_a;
   assign src_in[1]   = i_b;
   assign src_mode[0] = i_amod;
   assign src_mode[1] = i_bmod;
   assign native_uns  = op_native_unsigned(i_op);

   for (genvar s = 0; s < 2; s++) begin : g_src
      ivec_src_mod #(.W(DATA_W), .HS(HALF_SHIFT)) u_cond (
         .mode            (src_mode[s]),
         .native_unsigned (native_uns),
         .x               (src_in[s]),
         .raw             (src_raw[s]),
         .wide            (src_wide[s])
      );
   end

   ivec_exec #(.W(DATA_W)) u_exec (
      .op      (i_op),
      .a_raw   (src_raw[0]),
      .b_raw   (src_raw[1]),
      .a_wide  (src_wide[0]),
      .b_wide  (src_wide[1]),
      .full    (exec_full),
      .bitwise (exec_bw),
      .illegal (exec_ill)
   );

   ivec_finish #(.W(DATA_W)) u_fin (
      .full    (exec_full),
      .bitwise (exec_bw),
      .illegal (exec_ill),
      .fin     (i_omod),
      .res     (fin_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         o_valid   <= 1'b0;
         o_result  <= '0;
         o_illegal <= 1'b0;
      end else begin
         o_valid <= i_valid;
         if (i_valid) begin
            o_result  <= fin_res;
            o_illegal <= exec_ill;
         end
      end
   end

   p_illegal_zero_r13: assert property (@(posedge clk) disable iff (rst)
      o_illegal |-> (o_result == '0));

   p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
      i_valid |=> o_valid);

   p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !i_valid |=> (!o_valid && $stable(o_result) && $stable(o_illegal)));

   p_min_bound_r5: assert property (@(posedge clk) disable iff (rst)
      (i_op == OP_MIN_S || i_op == OP_MIN_U) |->
         ($signed(exec_full) <= $signed(src_wide[0]) &&
          $signed(exec_full) <= $signed(src_wide[1])));

   p_max_bound_r5: assert property (@(posedge clk) disable iff (rst)
      (i_op == OP_MAX_S || i_op == OP_MAX_U) |->
         ($signed(exec_full) >= $signed(src_wide[0]) &&
          $signed(exec_full) >= $signed(src_wide[1])));

   p_adiff_nonneg_r10: assert property (@(posedge clk) disable iff (rst)
      (i_op == OP_ADIFF_S || i_op == OP_ADIFF_U) |-> !exec_full[WIDE_W-1]);

endmodule

// File: tb/tb_ivec_alu.sv
module tb_ivec_alu;
   logic        clk = 1'b0;
   logic        rst;
   logic        i_valid;
   logic [7:0]  i_op;
   logic [31:0] i_a, i_b;
   logic [1:0]  i_amod, i_bmod, i_omod;
   logic        o_valid;
   logic [31:0] o_result;
   logic        o_illegal;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ivec_alu dut (
      .clk(clk), .rst(rst), .i_valid(i_valid), .i_op(i_op),
      .i_a(i_a), .i_b(i_b), .i_amod(i_amod), .i_bmod(i_bmod),
      .i_omod(i_omod), .o_valid(o_valid), .o_result(o_result),
      .o_illegal(o_illegal)
   );

   task automatic expect_out(input string tag, input logic v, input logic [31:0] r,
                             input logic ill);
      checks++;
      if (o_valid !== v || o_result !== r || o_illegal !== ill) begin
         errors++;
         $display("FAIL %s: got valid=%b result=%h illegal=%b, expected valid=%b result=%h illegal=%b",
                  tag, o_valid, o_result, o_illegal, v, r, ill);
      end
   endtask

   // drive on a falling edge, captured at the next rising edge, sampled on the following falling edge
   task automatic run(input string tag, input logic [7:0] op, input logic [31:0] a,
                      input logic [31:0] b, input logic [1:0] am, input logic [1:0] bm,
                      input logic [1:0] om, input logic [31:0] exp, input logic expill = 1'b0);
      @(negedge clk);
      i_op = op; i_a = a; i_b = b; i_amod = am; i_bmod = bm; i_omod = om; i_valid = 1'b1;
      @(negedge clk);
      i_valid = 1'b0;
      expect_out(tag, 1'b1, exp, expill);
   endtask

   task automatic t_reset;
      rst = 1'b1; i_valid = 1'b0; i_op = 8'h00; i_a = '0; i_b = '0;
      i_amod = 2'd2; i_bmod = 2'd2; i_omod = 2'd2;
      repeat (3) @(negedge clk);
      expect_out("R1 reset state", 1'b0, 32'h0, 1'b0);
      rst = 1'b0;
   endtask

   task automatic t_hold;
      run("R2 issue", 8'h40, 32'd5, 32'd7, 2'd2, 2'd2, 2'd2, 32'd12);
      i_op = 8'h46; i_a = 32'hDEAD; i_omod = 2'd0;
      repeat (2) @(negedge clk);
      expect_out("R2 hold while idle", 1'b0, 32'd12, 1'b0);
   endtask

   task automatic t_addsub;
      run("R3 add",          8'h40, 32'd5, 32'd7, 2'd2, 2'd2, 2'd2, 32'd12);
      run("R3 sub",          8'h46, 32'd3, 32'd5, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFE);
      run("R3 shifted add",  8'h41, 32'd10, 32'd3, 2'd2, 2'd2, 2'd2, 32'd16);
      run("R3 add high",     8'h40, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'd2, 2'd2, 2'd3, 32'hFFFFFFFF);
   endtask

   task automatic t_sat;
      run("R4 sadd clamp hi", 8'h48, 32'h7FFFFFFF, 32'd1, 2'd2, 2'd2, 2'd2, 32'h7FFFFFFF);
      run("R4 sadd clamp lo", 8'h48, 32'h80000000, 32'hFFFFFFFF, 2'd2, 2'd2, 2'd2, 32'h80000000);
      run("R4 sadd plain",    8'h48, 32'd2, 32'd3, 2'd2, 2'd2, 2'd2, 32'd5);
      run("R4 uadd clamp",    8'h49, 32'hFFFFFFF0, 32'h20, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFF);
      run("R4 ssub clamp",    8'h4E, 32'h80000000, 32'd1, 2'd2, 2'd2, 2'd2, 32'h80000000);
      run("R4 usub floor",    8'h4F, 32'd5, 32'd6, 2'd2, 2'd2, 2'd2, 32'h0);
   endtask

   task automatic t_minmax;
      run("R5 smin", 8'h60, 32'hFFFFFFFF, 32'd1, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFF);
      run("R5 umin", 8'h61, 32'hFFFFFFFF, 32'd1, 2'd2, 2'd2, 2'd2, 32'd1);
      run("R5 smax", 8'h62, 32'hFFFFFFFF, 32'd1, 2'd2, 2'd2, 2'd2, 32'd1);
      run("R5 umax", 8'h63, 32'hFFFFFFFF, 32'd1, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFF);
   endtask

   task automatic t_halving;
      run("R6 savg",       8'h64, 32'hFFFFFFFD, 32'd0, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFE);
      run("R6 uavg carry", 8'h65, 32'hFFFFFFFF, 32'hFFFFFFFE, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFE);
      run("R6 sravg",      8'h66, 32'hFFFFFFFD, 32'd0, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFF);
      run("R6 uravg carry",8'h67, 32'hFFFFFFFF, 32'hFFFFFFFE, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFF);
   endtask

   task automatic t_shift;
      run("R7 sra",        8'h68, 32'h80000000, 32'd4, 2'd2, 2'd2, 2'd2, 32'hF8000000);
      run("R7 srl",        8'h69, 32'h80000000, 32'd4, 2'd2, 2'd2, 2'd2, 32'h08000000);
      run("R7 sll low5",   8'h6E, 32'd1, 32'd33, 2'd2, 2'd2, 2'd2, 32'd2);
      run("R7 sll out",    8'h6E, 32'h80000001, 32'd1, 2'd2, 2'd2, 2'd3, 32'd1);
   endtask

   task automatic t_logic;
      run("R8 and",  8'h70, 32'hF0F0, 32'hFF00, 2'd2, 2'd2, 2'd2, 32'hF000);
      run("R8 or",   8'h71, 32'hF0F0, 32'hFF00, 2'd2, 2'd2, 2'd2, 32'hFFF0);
      run("R8 not",  8'h72, 32'h0F0F0F0F, 32'h0F0F0F0F, 2'd2, 2'd2, 2'd2, 32'hF0F0F0F0);
      run("R8 nor",  8'h73, 32'h0, 32'h0, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFF);
      run("R8 andn", 8'h74, 32'hFF, 32'h0F, 2'd2, 2'd2, 2'd2, 32'hF0);
      run("R8 orn",  8'h75, 32'h0, 32'hFFFFFFF0, 2'd2, 2'd2, 2'd2, 32'hF);
      run("R8 xor",  8'h76, 32'hFF, 32'h0F, 2'd2, 2'd2, 2'd2, 32'hF0);
      run("R8 xnor", 8'h77, 32'hFF, 32'h0F, 2'd2, 2'd2, 2'd2, 32'hFFFFFF0F);
   endtask

   task automatic t_count;
      run("R9 lzc zero", 8'h78, 32'h0, 32'h0, 2'd2, 2'd2, 2'd2, 32'd32);
      run("R9 lzc mid",  8'h78, 32'h00010000, 32'h0, 2'd2, 2'd2, 2'd2, 32'd15);
      run("R9 lzc top",  8'h78, 32'h80000000, 32'h0, 2'd2, 2'd2, 2'd2, 32'd0);
      run("R9 bytepop",  8'h7A, 32'hFF0F0301, 32'h0, 2'd2, 2'd2, 2'd2, 32'h08040201);
      run("R9 mov",      8'h7B, 32'h12345678, 32'h0, 2'd2, 2'd2, 2'd2, 32'h12345678);
   endtask

   task automatic t_adiff;
      run("R10 sadiff",   8'h7C, 32'hFFFFFFFB, 32'd3, 2'd2, 2'd2, 2'd2, 32'd8);
      run("R10 sadiff2",  8'h7C, 32'd1, 32'hFFFFFFFF, 2'd2, 2'd2, 2'd2, 32'd2);
      run("R10 uadiff",   8'h7D, 32'd1, 32'hFFFFFFFF, 2'd2, 2'd2, 2'd2, 32'hFFFFFFFE);
   endtask

   task automatic t_srcmod;
      run("R11 zext high", 8'h40, 32'hFFFFFFFF, 32'd1, 2'd1, 2'd2, 2'd3, 32'd1);
      run("R11 sext high", 8'h40, 32'hFFFFFFFF, 32'd1, 2'd0, 2'd2, 2'd3, 32'd0);
      run("R11 uphalf",    8'h40, 32'h00008000, 32'd0, 2'd3, 2'd2, 2'd2, 32'h80000000);
      run("R11 umin sext", 8'h61, 32'hFFFFFFFF, 32'd1, 2'd0, 2'd2, 2'd2, 32'hFFFFFFFF);
   endtask

   // conditioning and finishing on the same operation
   task automatic t_finish;
      run("R12 clamp s",  8'h40, 32'h00008000, 32'hFFFFFFFF, 2'd3, 2'd2, 2'd0, 32'h80000000);
      run("R12 clamp u",  8'h40, 32'h00008000, 32'hFFFFFFFF, 2'd3, 2'd2, 2'd1, 32'h0);
      run("R12 wrap",     8'h40, 32'h00008000, 32'hFFFFFFFF, 2'd3, 2'd2, 2'd2, 32'h7FFFFFFF);
      run("R12 upper",    8'h40, 32'h00008000, 32'hFFFFFFFF, 2'd3, 2'd2, 2'd3, 32'hFFFFFFFF);
      run("R12 sat s big",8'h40, 32'h7FFFFFFF, 32'd1, 2'd2, 2'd2, 2'd0, 32'h7FFFFFFF);
      run("R12 sat u ok", 8'h40, 32'd1, 32'd1, 2'd2, 2'd2, 2'd1, 32'd2);
      run("R12 bitwise s",8'h73, 32'h0, 32'h0, 2'd2, 2'd2, 2'd0, 32'hFFFFFFFF);
      run("R12 bitwise u",8'h73, 32'h0, 32'h0, 2'd2, 2'd2, 2'd1, 32'hFFFFFFFF);
      run("R12 bitwise hi",8'h73, 32'h0, 32'h0, 2'd2, 2'd2, 2'd3, 32'h0);
   endtask

   task automatic t_illegal;
      run("R13 bad op",      8'h42, 32'd5, 32'd7, 2'd2, 2'd2, 2'd3, 32'h0, 1'b1);
      run("R13 bad op gap",  8'h79, 32'hFFFFFFFF, 32'd1, 2'd2, 2'd2, 2'd2, 32'h0, 1'b1);
      run("R13 legal clears",8'h40, 32'd1, 32'd2, 2'd2, 2'd2, 2'd2, 32'd3, 1'b0);
   endtask

   initial begin
      t_reset();
      t_hold();
      t_addsub();
      t_sat();
      t_minmax();
      t_halving();
      t_shift();
      t_logic();
      t_count();
      t_adiff();
      t_srcmod();
      t_finish();
      t_illegal();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got a hung run, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule